// File: doc/BRIEF.md
# Indexed Configuration Port with Unlock Key

This block is the configuration front end of a multi-function I/O controller. Host software reaches it through two adjacent byte-wide I/O addresses. The lower address holds an index register and the upper address is a data window onto whichever configuration register the index selects. A strap input picks which of two base addresses responds. The port stays closed until software writes a two-byte entry key to the index address, and a single exit byte closes it again.

While the port is open, the low indices reach a small set of global registers: a logical device selector, read-only identity bytes and a register that reports the base-address strap. Indices from 0x30 upward belong to the device bank chosen by the selector. When the selector names the one device wired to this port, those accesses go out on a simple register bus with address, write data, write strobe, read strobe and read data. The function logic behind that bus lies outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: The index register answers at the base address and the data window at base+1. The base is 0x2E when `strap_base_hi` is 0 and 0x4E when it is 1. A read at any other address returns 0xFF, and a write there has no effect.
- R2: Two consecutive writes of 0x87 to the index address open the port.
- R3: After a first 0x87, any other index write value closes the key sequence, so two more 0x87 writes are then needed. Data-address accesses do not affect the key sequence.
- R4: While the port is open, writing 0xAA to the index address closes it and leaves the index unchanged. Any other index write value becomes the new index.
- R5: While the port is closed, every read returns 0xFF. Writes change no register and raise no device strobe.
- R6: Global index 0x07 is a readable and writable logical device number.
- R7: Index 0x20 reads the device ID parameter (default 0x52) and index 0x21 reads the revision parameter (default 0x17). Writes to these indices have no effect.
- R8: Index 0x26 reads bit 6 equal to `strap_base_hi`, with all other bits 0.
- R9: With the device number equal to 0x08 and the index at 0x30 or above, a data write pulses `dev_wr` for one cycle with `dev_addr` equal to the index and `dev_wdata` equal to the written byte. A data read pulses `dev_rd`, and `dev_rdata` is returned.
- R10: With any other device number, indices of 0x30 and above read 0xFF and raise no device strobe.
- R11: Read data is registered and appears on `io_rdata` in the cycle after `io_rd`. A read of the index address returns the current index. Unassigned global indices below 0x30 read 0xFF.
- R12: Reset leaves the port closed, the device number at 0 and the index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_base_hi | input | 1 | Base select strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| dev_addr | output | 8 | Bank register index to the device |
| dev_wdata | output | 8 | Write data to the device |
| dev_wr | output | 1 | Device write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_rdata | input | 8 | Device read data, valid combinationally during `dev_rd` |

## Verification
The key state, the index and the device number all change at the clock edge that samples a write. Their effect can therefore be observed by any access issued from the next cycle on. Read data is registered, so `io_rdata` is sampled on the falling edge that follows the rising edge where `io_rd` was seen. Device strobes are combinational with the I/O strobe, so the bench counts them at that same rising edge and compares the counts one half cycle later. A bench model of the key sequence, index and device number predicts every read value and every strobe count, both for directed corner cases and for a seeded random mix of accesses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        KEY_CLOSED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] rdata;
    } cfg_regs_t;

    localparam logic [7:0] KEY_ENTER      = 8'h87;
    localparam logic [7:0] KEY_EXIT       = 8'hAA;
    localparam logic [7:0] IDX_LDN        = 8'h07;
    localparam logic [7:0] IDX_DEVID      = 8'h20;
    localparam logic [7:0] IDX_DEVREV     = 8'h21;
    localparam logic [7:0] IDX_STRAP      = 8'h26;
    localparam logic [7:0] IDX_BANK_FIRST = 8'h30;
    localparam logic [7:0] FILL_BYTE      = 8'hFF;
    localparam int         STRAP_BIT      = 6;

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strap_hi,
    output logic              hit_idx,
    output logic              hit_data
);
    logic [ADDR_W-1:0] base;
    logic              pair_hit;

    always_comb begin
        base     = strap_hi ? BASE_HI : BASE_LO;
        pair_hit = (addr[ADDR_W-1:1] == base[ADDR_W-1:1]);
        hit_idx  = pair_hit && !addr[0];
        hit_data = pair_hit &&  addr[0];
    end
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            case (state_q)
                KEY_CLOSED: state_d = (wdata == KEY_ENTER) ? KEY_HALF : KEY_CLOSED;
                KEY_HALF:   state_d = (wdata == KEY_ENTER) ? KEY_OPEN : KEY_CLOSED;
                KEY_OPEN:   state_d = (wdata == KEY_EXIT)  ? KEY_CLOSED : KEY_OPEN;
                default:    state_d = KEY_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_CLOSED;
        else        state_q <= state_d;
    end

    assign open = (state_q == KEY_OPEN);
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_LO  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI  = 16'h004E,
    parameter logic [7:0]        DEV_ID   = 8'h52,
    parameter logic [7:0]        DEV_REV  = 8'h17,
    parameter logic [7:0]        BANK_LDN = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_base_hi,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic [7:0]        dev_addr,
    output logic [7:0]        dev_wdata,
    output logic              dev_wr,
    output logic              dev_rd,
    input  logic [7:0]        dev_rdata
);
    cfg_regs_t  regs_d, regs_q;
    logic       hit_idx, hit_data;
    logic       cfg_open;
    logic       idx_wr, data_wr, data_rd;
    logic       bank_sel;
    logic [7:0] glob_rd;
    logic [7:0] cur_index, cur_ldn;

    sio_addr_decode #(
        .ADDR_W (ADDR_W),
        .BASE_LO(BASE_LO),
        .BASE_HI(BASE_HI)
    ) u_dec (
        .addr    (io_addr),
        .strap_hi(strap_base_hi),
        .hit_idx (hit_idx),
        .hit_data(hit_data)
    );

    sio_key_fsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_wr(idx_wr),
        .wdata (io_wdata),
        .open  (cfg_open)
    );

    assign cur_index = regs_q.index;
    assign cur_ldn   = regs_q.ldn;

    always_comb begin
        idx_wr   = io_wr && hit_idx;
        data_wr  = io_wr && hit_data && cfg_open;
        data_rd  = io_rd && hit_data && cfg_open;
        bank_sel = (regs_q.index >= IDX_BANK_FIRST) && (regs_q.ldn == BANK_LDN);

        dev_addr  = regs_q.index;
        dev_wdata = io_wdata;
        dev_wr    = data_wr && bank_sel;
        dev_rd    = data_rd && bank_sel;

        case (regs_q.index)
            IDX_LDN:    glob_rd = regs_q.ldn;
            IDX_DEVID:  glob_rd = DEV_ID;
            IDX_DEVREV: glob_rd = DEV_REV;
            IDX_STRAP:  glob_rd = 8'(strap_base_hi) << STRAP_BIT;
            default:    glob_rd = FILL_BYTE;
        endcase

        regs_d = regs_q;
        if (idx_wr && cfg_open && (io_wdata != KEY_EXIT))
            regs_d.index = io_wdata;
        if (data_wr && (regs_q.index == IDX_LDN))
            regs_d.ldn = io_wdata;
        if (io_rd) begin
            if (cfg_open && hit_idx)
                regs_d.rdata = regs_q.index;
            else if (cfg_open && hit_data) begin
                if (regs_q.index < IDX_BANK_FIRST) regs_d.rdata = glob_rd;
                else if (bank_sel)                 regs_d.rdata = dev_rdata;
                else                               regs_d.rdata = FILL_BYTE;
            end else
                regs_d.rdata = FILL_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{index: 8'h00, ldn: 8'h00, rdata: FILL_BYTE};
        else        regs_q <= regs_d;
    end

    assign io_rdata = regs_q.rdata;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] BANK_LDN = 8'h08
) (
    input logic       clk,
    input logic       rst_n,
    input logic       io_wr,
    input logic       io_rd,
    input logic [7:0] io_wdata,
    input logic       hit_idx,
    input logic       cfg_open,
    input logic [7:0] cur_index,
    input logic [7:0] cur_ldn,
    input logic       dev_wr,
    input logic       dev_rd
);
    assert_closed_no_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> cfg_open);

    assert_closed_no_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> (cfg_open && io_rd));

    assert_ldn_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(cur_ldn));

    assert_bank_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (io_wr && cur_ldn == BANK_LDN && cur_index >= IDX_BANK_FIRST));

    assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && hit_idx && io_wdata == KEY_ENTER));

    assert_exit_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && hit_idx && io_wdata == KEY_EXIT) |=> !cfg_open);

    assert_exit_keeps_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_idx && io_wdata == KEY_EXIT) |=> $stable(cur_index));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.BANK_LDN(BANK_LDN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .hit_idx  (hit_idx),
    .cfg_open (cfg_open),
    .cur_index(cur_index),
    .cur_ldn  (cur_ldn),
    .dev_wr   (dev_wr),
    .dev_rd   (dev_rd)
);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;
    localparam logic [7:0] ID  = 8'h52;
    localparam logic [7:0] REV = 8'h17;
    localparam logic [7:0] DEV_XOR = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [7:0]  dev_addr, dev_wdata, dev_rdata;
    logic        dev_wr, dev_rd;

    always #10 clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .strap_base_hi(strap),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
    );

    // simple device behind the bank bus
    assign dev_rdata = dev_addr ^ DEV_XOR;
    int         wcnt = 0, rcnt = 0;
    logic [7:0] last_wa, last_wd;
    always @(posedge clk) begin
        if (dev_wr) begin wcnt <= wcnt + 1; last_wa <= dev_addr; last_wd <= dev_wdata; end
        if (dev_rd) rcnt <= rcnt + 1;
    end

    int n_tests = 0, n_fail = 0;
    // model: 0 closed, 1 half, 2 open
    int         m_key = 0;
    logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base_of();
        return strap ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (m_key != 2) return 8'hFF;
        if (a == base_of()) return m_idx;
        if (a != base_of() + 16'd1) return 8'hFF;
        if (m_idx >= 8'h30) return (m_ldn == 8'h08) ? (m_idx ^ DEV_XOR) : 8'hFF;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return ID;
            8'h21: return REV;
            8'h26: return {1'b0, strap, 6'b0};
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit exp_bank(input logic [15:0] a);
        return (m_key == 2) && (a == base_of() + 16'd1) && (m_idx >= 8'h30) && (m_ldn == 8'h08);
    endfunction

    task automatic io_write(input string req, input logic [15:0] a, input logic [7:0] d);
        int  w0 = wcnt;
        bit  eb = exp_bank(a);
        logic [7:0] ea = m_idx;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == base_of()) begin
            case (m_key)
                0: m_key = (d == 8'h87) ? 1 : 0;
                1: m_key = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_key = 0; else m_idx = d;
            endcase
        end else if (a == base_of() + 16'd1 && m_key == 2 && m_idx == 8'h07) m_ldn = d;
        chk({req, " dev write count"}, 8'(wcnt - w0), eb ? 8'd1 : 8'd0);
        if (eb) begin
            chk({req, " dev_addr"}, last_wa, ea);
            chk({req, " dev_wdata"}, last_wd, d);
        end
    endtask

    task automatic io_read(input string req, input logic [15:0] a);
        int r0 = rcnt;
        logic [7:0] e = exp_read(a);
        bit eb = exp_bank(a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        chk(req, io_rdata, e);
        chk({req, " dev read count"}, 8'(rcnt - r0), eb ? 8'd1 : 8'd0);
    endtask

    task automatic unlock();
        io_write("R2 key1", base_of(), 8'h87);
        io_write("R2 key2", base_of(), 8'h87);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state closed
        chk("R12 rdata after reset", io_rdata, 8'hFF);
        io_read("R12 closed data read", 16'h002F);
        io_read("R5 closed index read", 16'h002E);
        io_write("R5 closed write", 16'h002F, 8'h55);
        // R3: broken sequence
        io_write("R3 key first", 16'h002E, 8'h87);
        io_write("R3 break", 16'h002E, 8'h55);
        io_write("R3 key again", 16'h002E, 8'h87);
        io_read("R3 still closed", 16'h002F);
        io_write("R3 data write in half", 16'h002F, 8'h11);
        io_write("R3 second key", 16'h002E, 8'h87);
        chk("R3 model open", 8'(m_key), 8'd2);
        io_read("R12 index after reset R11", 16'h002E);
        io_write("R6 sel ldn", 16'h002E, 8'h07);
        io_read("R12 ldn reset value", 16'h002F);
        io_write("R7 sel id", 16'h002E, 8'h20);
        io_read("R7 device id", 16'h002F);
        io_write("R7 write id ignored", 16'h002F, 8'h00);
        io_read("R7 id unchanged", 16'h002F);
        io_write("R7 sel rev", 16'h002E, 8'h21);
        io_read("R7 revision", 16'h002F);
        io_write("R8 sel strap reg", 16'h002E, 8'h26);
        io_read("R8 strap low", 16'h002F);
        io_write("R11 sel hole", 16'h002E, 8'h10);
        io_read("R11 unassigned", 16'h002F);
        io_read("R11 index readback", 16'h002E);
        io_write("R6 sel ldn", 16'h002E, 8'h07);
        io_write("R6 write ldn", 16'h002F, 8'h08);
        io_read("R6 ldn readback", 16'h002F);
        io_write("R9 sel bank", 16'h002E, 8'h30);
        io_write("R9 bank write", 16'h002F, 8'hA5);
        io_read("R9 bank read", 16'h002F);
        io_write("R9 sel top", 16'h002E, 8'hFF);
        io_read("R9 bank read top", 16'h002F);
        io_write("R1 foreign write", 16'h004F, 8'h77);
        io_read("R1 foreign read", 16'h004F);
        io_read("R1 foreign read 2", 16'h0060);
        io_write("R6 sel ldn", 16'h002E, 8'h07);
        io_write("R10 other ldn", 16'h002F, 8'h03);
        io_write("R10 sel bank", 16'h002E, 8'hF0);
        io_read("R10 other ldn read", 16'h002F);
        io_write("R10 other ldn write", 16'h002F, 8'h99);
        // R4 exit then R5 write ignored
        io_write("R6 sel ldn", 16'h002E, 8'h07);
        io_write("R4 exit", 16'h002E, 8'hAA);
        io_read("R4 closed after exit", 16'h002F);
        io_write("R5 closed ldn write", 16'h002F, 8'h44);
        unlock();
        io_read("R4 index kept over exit", 16'h002E);
        io_read("R5 ldn unchanged", 16'h002F);
        io_write("R6 restore ldn", 16'h002F, 8'h08);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 10;
            int s = $urandom % 8;
            logic [15:0] a;
            logic [7:0]  d;
            case ($urandom % 5)
                0, 1: a = base_of();
                2, 3: a = base_of() + 16'd1;
                default: a = strap ? 16'h002F : 16'h004E;
            endcase
            case (s)
                0, 1: d = 8'h87;
                2: d = 8'hAA;
                3: d = 8'h07;
                4: d = 8'h20 + 8'($urandom % 7);
                5: d = 8'h30 + 8'($urandom % 16);
                6: d = (m_idx == 8'h07) ? 8'h08 : 8'($urandom);
                default: d = 8'($urandom);
            endcase
            if (r < 5) io_write("R1 R3 R4 R9 random write", a, d);
            else       io_read("R5 R9 R10 R11 random read", a);
        end
        // strap high: R1 R8
        if (m_key != 2) unlock();
        io_write("R4 exit before strap", base_of(), 8'hAA);
        strap = 1'b1;
        io_write("R1 old base key", 16'h002E, 8'h87);
        io_write("R1 old base key", 16'h002E, 8'h87);
        io_read("R1 old base silent", 16'h002F);
        unlock();
        io_write("R8 sel strap reg", 16'h004E, 8'h26);
        io_read("R8 strap high", 16'h004F);
        io_read("R1 old base data", 16'h002F);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule